// File: doc/BRIEF.md
# Sample-Point Drift Monitor

After the input-capture sampling point has been calibrated, this block watches it for drift. Each time an external edge-search engine reports a setup margin and a hold margin, the block converts the pair into an instantaneous imbalance, half of the hold result minus the setup result. It then feeds that imbalance through a first-order averaging filter whose gain is a power of two selected by a filter-length field. The filtered average is held in signed fixed point with `FRAC` fractional bits, so that the tiny steps of a long filter are not lost.

When monitoring is enabled and the magnitude of the updated average goes beyond a 2-bit threshold, the block takes one of two actions. In interrupt mode it raises a sticky interrupt. In automatic mode it shifts the sample-delay code by the rounded average, saturating the result to the code range, and then restarts the average from zero. The sample-delay code is first loaded from the calibration result through a load strobe.

Top module: `drift_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq` is 0, `avg_q` is 0 and `sd_code` is 0.
- R2: With filter length 0, one cycle after a measurement pulse `avg_q` equals (hold − setup) × 2^(FRAC−1). This is the half-difference expressed in units of 2^−FRAC delay steps.
- R3: On each measurement, `avg_q` becomes avg + floor((inst − avg) / 2^L). Here inst is the R2 value and L is the filter length. Without a measurement, `avg_q` holds its value.
- R4: A filter-length value above MAX_FLT (12) gives exactly the same result as MAX_FLT.
- R5: While `mon_en` is 0, measurements are ignored and `avg_q` is 0 from the next cycle on; `irq` and `sd_code` are unchanged.
- R6: A measurement whose updated average has magnitude strictly greater than `thresh` × 2^FRAC is an exceedance. An equal magnitude is not an exceedance.
- R7: In interrupt mode (`auto_en` = 0, or `irq_en` = 1), an exceedance sets `irq` in the following cycle. `irq` stays set until a cycle with `irq_clr` = 1. A set in the same cycle as a clear wins.
- R8: Automatic mode is active when `mon_en` = 1, `auto_en` = 1 and `irq_en` = 0. In this mode an exceedance moves `sd_code` by floor(avg/2^FRAC + 1/2), saturated to 0..2^DW−1, and clears `avg_q` to 0. `irq` is never set in this mode.
- R9: With `auto_en` = 1 and `irq_en` = 1, an exceedance raises `irq` and leaves `sd_code` unchanged.
- R10: `sd_load` writes `sd_load_val` into `sd_code` and clears `avg_q` in the next cycle. It takes priority over a measurement in the same cycle, which is then discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Monitor enable |
| auto_en | input | 1 | Automatic correction request |
| irq_en | input | 1 | Interrupt enable; when high, correction is replaced by the interrupt |
| flt_len | input | FLW | Filter length L (gain 2^−L) |
| thresh | input | TW | Drift threshold in whole delay steps |
| meas_valid | input | 1 | One-cycle strobe: new margin pair present |
| setup_meas | input | DW | Setup margin count |
| hold_meas | input | DW | Hold margin count |
| sd_load | input | 1 | Load strobe for the sample-delay code |
| sd_load_val | input | DW | Calibrated sample-delay code |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| irq | output | 1 | Sticky drift interrupt |
| avg_q | output | DW+FRAC+1 | Filtered average, signed, FRAC fractional bits |
| sd_code | output | DW | Current sample-delay code |

## Verification
The hardest states to reach are the two ends of the sample-delay range under automatic correction, together with the exact half-step rounding point. The average is filtered, so a gradual drift seldom lands on those values. The stimulus therefore uses filter length 0 and threshold 0, which makes every measurement act at once. It feeds maximum-imbalance margin pairs (hold 7 or setup 15), which produce averages of exactly +3.5 and −7.5 steps. Repeated corrections then drive the code into both saturation limits, and each intermediate code checks the round-half-up rule.

// File: rtl/drift_mon_pkg.sv
package drift_mon_pkg;

   // operating mode decoded from the enable inputs
   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_WATCH = 2'd1,
      MODE_AUTO  = 2'd2
   } mon_mode_e;

   function automatic mon_mode_e decode_mode(input logic mon, input logic aut, input logic ien);
      if (!mon)
         return MODE_OFF;
      else if (aut && !ien)
         return MODE_AUTO;
      else
         return MODE_WATCH;
   endfunction

endpackage

// File: rtl/drift_mon_inst.sv
module drift_mon_inst #(
   parameter int DW      = 4,
   parameter int FRAC    = 12,
   parameter int FLW     = 4,
   parameter int MAX_FLT = 12,
   parameter int AVG_W   = DW + FRAC + 1,
   parameter int SHW     = 4
) (
   input  logic [DW-1:0]           setup_i,
   input  logic [DW-1:0]           hold_i,
   input  logic [FLW-1:0]          flen_i,
   output logic signed [AVG_W-1:0] inst_o,
   output logic [SHW-1:0]          sh_o
);

   localparam int DIFF_W  = DW + 1;
   localparam int FLW_TOP = (2 ** FLW) - 1;

   logic signed [DIFF_W-1:0] diff;

   // half of (hold - setup), scaled to FRAC fractional bits
   always_comb begin
      diff   = $signed({1'b0, hold_i}) - $signed({1'b0, setup_i});
      inst_o = AVG_W'(diff) <<< (FRAC - 1);
   end

   // filter-length clamp only when the field can encode an illegal value
   generate
      if (FLW_TOP > MAX_FLT) begin : g_clamp
         assign sh_o = (flen_i > FLW'(MAX_FLT)) ? SHW'(MAX_FLT) : SHW'(flen_i);
      end else begin : g_pass
         assign sh_o = SHW'(flen_i);
      end
   endgenerate

endmodule

// File: rtl/drift_mon_filt.sv
module drift_mon_filt #(
   parameter int AVG_W = 17,
   parameter int SHW   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd_i,
   input  logic                    clr_i,
   input  logic signed [AVG_W-1:0] inst_i,
   input  logic [SHW-1:0]          sh_i,
   output logic signed [AVG_W-1:0] avg_nxt_o,
   output logic signed [AVG_W-1:0] avg_o
);

   localparam int DW_EXT = AVG_W + 1;

   logic signed [DW_EXT-1:0] delta;
   logic signed [DW_EXT-1:0] step;

   always_comb begin
      delta     = DW_EXT'(inst_i) - DW_EXT'(avg_o);
      step      = delta >>> sh_i;
      avg_nxt_o = avg_o + AVG_W'(step);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         avg_o <= '0;
      else if (clr_i)
         avg_o <= '0;
      else if (upd_i)
         avg_o <= avg_nxt_o;
   end

   // R3: without an update the average is held
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_i && !clr_i) |=> $stable(avg_o));

   // R3: an update moves the average toward the sample, never past it
   p_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !clr_i) |=>
         ((avg_o >= $past(avg_o) && avg_o <= $past(inst_i)) ||
          (avg_o <= $past(avg_o) && avg_o >= $past(inst_i))));

   // R10: a clear empties the average
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (avg_o == '0));

endmodule

// File: rtl/drift_mon_judge.sv
module drift_mon_judge #(
   parameter int DW            = 4,
   parameter int FRAC          = 12,
   parameter int TW            = 2,
   parameter int AVG_W         = DW + FRAC + 1,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic signed [AVG_W-1:0] avg_i,
   input  logic [TW-1:0]           thr_i,
   input  logic [DW-1:0]           sd_i,
   output logic                    over_o,
   output logic [DW-1:0]           sd_o
);

   localparam int EW = AVG_W + 2;
   localparam logic signed [EW-1:0] SD_MAX = EW'((2 ** DW) - 1);
   localparam logic signed [EW-1:0] HALF   = EW'(2 ** (FRAC - 1));

   logic signed [EW-1:0] avg_x;
   logic signed [EW-1:0] mag;
   logic signed [EW-1:0] lim;
   logic signed [EW-1:0] rnd;
   logic signed [EW-1:0] sum;

   always_comb begin
      avg_x  = EW'(avg_i);
      mag    = (avg_x < 0) ? -avg_x : avg_x;
      lim    = $signed(EW'(thr_i)) <<< FRAC;
      over_o = (mag > lim);
   end

   // whole-step conversion of the average
   generate
      if (ROUND_NEAREST) begin : g_round
         assign rnd = (avg_x + HALF) >>> FRAC;
      end else begin : g_floor
         assign rnd = avg_x >>> FRAC;
      end
   endgenerate

   // move and saturate the delay code
   always_comb begin
      sum = $signed(EW'({1'b0, sd_i})) + rnd;
      if (sum < 0)
         sd_o = '0;
      else if (sum > SD_MAX)
         sd_o = '1;
      else
         sd_o = sum[DW-1:0];
   end

endmodule

// File: rtl/drift_mon.sv
module drift_mon
   import drift_mon_pkg::*;
#(
   parameter int DW            = 4,
   parameter int FRAC          = 12,
   parameter int FLW           = 4,
   parameter int MAX_FLT       = 12,
   parameter int TW            = 2,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mon_en,
   input  logic                     auto_en,
   input  logic                     irq_en,
   input  logic [FLW-1:0]           flt_len,
   input  logic [TW-1:0]            thresh,
   input  logic                     meas_valid,
   input  logic [DW-1:0]            setup_meas,
   input  logic [DW-1:0]            hold_meas,
   input  logic                     sd_load,
   input  logic [DW-1:0]            sd_load_val,
   input  logic                     irq_clr,
   output logic                     irq,
   output logic signed [DW+FRAC:0]  avg_q,
   output logic [DW-1:0]            sd_code
);

   localparam int AVG_W = DW + FRAC + 1;
   localparam int SHW   = $clog2(MAX_FLT + 1);

   // elaboration-time parameter checks
   generate
      if (FRAC < 1) begin : g_bad_frac
         $error("drift_mon: FRAC must be at least 1");
      end
      if (MAX_FLT > FRAC) begin : g_bad_flt
         $error("drift_mon: MAX_FLT must not exceed FRAC");
      end
      if (DW < 2) begin : g_bad_dw
         $error("drift_mon: DW must be at least 2");
      end
   endgenerate

   mon_mode_e                mode;
   logic signed [AVG_W-1:0]  inst_fx;
   logic [SHW-1:0]           shamt;
   logic signed [AVG_W-1:0]  avg_nxt;
   logic                     over;
   logic [DW-1:0]            sd_next;
   logic                     take;
   logic                     fire;
   logic                     do_fix;
   logic                     irq_set;
   logic                     avg_clr;

   always_comb begin
      mode    = decode_mode(mon_en, auto_en, irq_en);
      take    = meas_valid && (mode != MODE_OFF) && !sd_load;
      fire    = take && over;
      do_fix  = fire && (mode == MODE_AUTO);
      irq_set = fire && (mode == MODE_WATCH);
      avg_clr = (mode == MODE_OFF) || sd_load || do_fix;
   end

   drift_mon_inst #(
      .DW(DW), .FRAC(FRAC), .FLW(FLW), .MAX_FLT(MAX_FLT), .AVG_W(AVG_W), .SHW(SHW)
   ) u_inst (
      .setup_i (setup_meas),
      .hold_i  (hold_meas),
      .flen_i  (flt_len),
      .inst_o  (inst_fx),
      .sh_o    (shamt)
   );

   drift_mon_filt #(
      .AVG_W(AVG_W), .SHW(SHW)
   ) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_i     (take),
      .clr_i     (avg_clr),
      .inst_i    (inst_fx),
      .sh_i      (shamt),
      .avg_nxt_o (avg_nxt),
      .avg_o     (avg_q)
   );

   drift_mon_judge #(
      .DW(DW), .FRAC(FRAC), .TW(TW), .AVG_W(AVG_W), .ROUND_NEAREST(ROUND_NEAREST)
   ) u_judge (
      .avg_i  (avg_nxt),
      .thr_i  (thresh),
      .sd_i   (sd_code),
      .over_o (over),
      .sd_o   (sd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         sd_code <= '0;
      else if (sd_load)
         sd_code <= sd_load_val;
      else if (do_fix)
         sd_code <= sd_next;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq <= 1'b0;
      else if (irq_set)
         irq <= 1'b1;
      else if (irq_clr)
         irq <= 1'b0;
   end

   // R7: the interrupt only falls on a clear request
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   // R8: automatic mode never raises the interrupt
   p_auto_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && auto_en && !irq_en && !irq) |=> !irq);

   // R5: a disabled monitor keeps a zero average
   p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_en |=> (avg_q == '0));

   // R10: load writes the calibrated code
   p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sd_load |=> (sd_code == $past(sd_load_val)));

   // R9: outside automatic mode the delay code only changes through a load
   p_sd_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_load && !(mon_en && auto_en && !irq_en)) |=> $stable(sd_code));

endmodule

// File: tb/drift_mon_tb.sv
`timescale 1ns/1ps
module drift_mon_tb_top;

   localparam int DW   = 4;
   localparam int FRAC = 12;
   localparam int FLW  = 4;
   localparam int TW   = 2;
   localparam int AW   = DW + FRAC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mon_en = 1'b0, auto_en = 1'b0, irq_en = 1'b0;
   logic [FLW-1:0] flt_len = '0;
   logic [TW-1:0]  thresh = '0;
   logic meas_valid = 1'b0;
   logic [DW-1:0] setup_meas = '0, hold_meas = '0;
   logic sd_load = 1'b0;
   logic [DW-1:0] sd_load_val = '0;
   logic irq_clr = 1'b0;
   logic irq;
   logic signed [AW-1:0] avg_q;
   logic [DW-1:0] sd_code;

   int n_run = 0;
   int n_fail = 0;

   // bench-side model of the requirements
   int m_avg = 0;
   int m_sd = 0;
   int m_irq = 0;
   int c_mon = 0, c_auto = 0, c_ien = 0, c_len = 0, c_thr = 0;

   always #2 clk = ~clk;

   drift_mon dut_i (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .auto_en(auto_en), .irq_en(irq_en),
      .flt_len(flt_len), .thresh(thresh), .meas_valid(meas_valid),
      .setup_meas(setup_meas), .hold_meas(hold_meas), .sd_load(sd_load),
      .sd_load_val(sd_load_val), .irq_clr(irq_clr), .irq(irq), .avg_q(avg_q),
      .sd_code(sd_code)
   );

   task automatic chk(input string req, input int act, input int exp, input string what);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, int'(irq), m_irq, "irq");
      chk(req, int'($signed(avg_q)), m_avg, "avg_q");
      chk(req, int'(sd_code), m_sd, "sd_code");
   endtask

   task automatic cfg(input int mon, input int aut, input int ien, input int len, input int thr);
      @(negedge clk);
      mon_en = mon[0]; auto_en = aut[0]; irq_en = ien[0];
      flt_len = FLW'(len); thresh = TW'(thr);
      c_mon = mon; c_auto = aut; c_ien = ien; c_len = len; c_thr = thr;
      @(negedge clk);
      if (c_mon == 0) m_avg = 0;
   endtask

   // one clock with optional measurement, clear and load; model updated per R2..R10
   task automatic step(input int valid, input int s, input int h, input int clr,
                       input int load, input int lval);
      int k, inst, lim, r, nsd;
      @(negedge clk);
      meas_valid = valid[0]; setup_meas = DW'(s); hold_meas = DW'(h);
      irq_clr = clr[0]; sd_load = load[0]; sd_load_val = DW'(lval);
      @(negedge clk);
      meas_valid = 1'b0; irq_clr = 1'b0; sd_load = 1'b0;
      if (clr != 0) m_irq = 0;
      if (load != 0) begin
         m_sd = lval; m_avg = 0;
      end else if (c_mon == 0) begin
         m_avg = 0;
      end else if (valid != 0) begin
         k = (c_len > 12) ? 12 : c_len;
         inst = (h - s) * (1 << (FRAC - 1));
         m_avg = m_avg + ((inst - m_avg) >>> k);
         lim = c_thr * (1 << FRAC);
         if ((m_avg < 0 ? -m_avg : m_avg) > lim) begin
            if (c_auto != 0 && c_ien == 0) begin
               r = (m_avg + (1 << (FRAC - 1))) >>> FRAC;
               nsd = m_sd + r;
               m_sd = (nsd < 0) ? 0 : (nsd > 15 ? 15 : nsd);
               m_avg = 0;
            end else begin
               m_irq = 1;
            end
         end
      end
   endtask

   task automatic meas(input int s, input int h);
      step(1, s, h, 0, 0, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk_all("R1");
   endtask

   task automatic t_inst;
      cfg(1, 0, 1, 0, 3);
      meas(3, 9);
      chk("R2", int'($signed(avg_q)), 6 * 2048, "avg_q +3.0");
      chk_all("R2");
      meas(9, 3);
      chk("R2", int'($signed(avg_q)), -6 * 2048, "avg_q -3.0");
      chk("R6", int'(irq), 0, "irq at equal magnitude");
   endtask

   task automatic t_filter;
      cfg(1, 0, 1, 2, 3);
      meas(5, 8);  chk_all("R3");
      meas(2, 10); chk_all("R3");
      meas(7, 7);  chk_all("R3");
      step(0, 0, 0, 0, 0, 0); chk_all("R3");
      meas(0, 12); chk_all("R3");
   endtask

   task automatic t_clamp;
      cfg(1, 0, 1, 15, 3);
      meas(0, 15); chk_all("R4");
      meas(0, 15); chk_all("R4");
      cfg(1, 0, 1, 13, 3);
      meas(15, 0); chk_all("R4");
   endtask

   task automatic t_disable;
      int irq_before, sd_before;
      irq_before = m_irq; sd_before = m_sd;
      cfg(0, 0, 1, 0, 0);
      chk("R5", int'($signed(avg_q)), 0, "avg_q after disable");
      meas(0, 15);
      chk("R5", int'($signed(avg_q)), 0, "avg_q ignored meas");
      chk("R5", int'(irq), irq_before, "irq untouched");
      chk("R5", int'(sd_code), sd_before, "sd_code untouched");
   endtask

   task automatic t_thresh;
      step(0, 0, 0, 1, 0, 0);
      chk("R7", int'(irq), 0, "irq cleared");
      cfg(1, 0, 1, 0, 1);
      meas(4, 5);
      chk("R6", int'(irq), 0, "0.5 below threshold 1");
      meas(0, 5);
      chk("R6", int'(irq), 1, "2.5 above threshold 1");
      step(0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      chk("R7", int'(irq), 1, "irq sticky");
      step(0, 0, 0, 1, 0, 0);
      chk("R7", int'(irq), 0, "irq after clear");
      step(1, 0, 6, 1, 0, 0);
      chk("R7", int'(irq), 1, "set beats clear");
      chk_all("R7");
   endtask

   task automatic t_load;
      step(0, 0, 0, 1, 1, 8);
      chk("R10", int'(sd_code), 8, "sd_code loaded");
      chk("R10", int'($signed(avg_q)), 0, "avg cleared by load");
      step(1, 0, 12, 0, 1, 9);
      chk("R10", int'(sd_code), 9, "load wins over meas");
      chk("R10", int'($signed(avg_q)), 0, "meas discarded");
      chk("R10", int'(irq), 0, "no irq from discarded meas");
      step(0, 0, 0, 0, 1, 8);
   endtask

   task automatic t_auto;
      cfg(1, 1, 0, 0, 0);
      meas(0, 7);
      chk("R8", int'(sd_code), 12, "8 + round(3.5)");
      chk("R8", int'($signed(avg_q)), 0, "avg reset after fix");
      meas(0, 7);
      chk("R8", int'(sd_code), 15, "saturate high");
      meas(15, 0);
      chk("R8", int'(sd_code), 8, "15 + round(-7.5)");
      meas(15, 0);
      chk("R8", int'(sd_code), 1, "8 - 7");
      meas(15, 0);
      chk("R8", int'(sd_code), 0, "saturate low");
      chk("R8", int'(irq), 0, "no irq in auto");
      chk_all("R8");
   endtask

   task automatic t_auto_irq;
      cfg(1, 1, 1, 0, 0);
      meas(0, 7);
      chk("R9", int'(irq), 1, "irq with enable set");
      chk("R9", int'(sd_code), 0, "sd_code unchanged");
      chk_all("R9");
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_all("R1");
      rst_n = 1'b1;
      t_reset();
      t_inst();
      t_filter();
      t_clamp();
      t_disable();
      t_thresh();
      t_load();
      t_auto();
      t_auto_irq();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule